// File: doc/BRIEF.md
# ADC trigger and transfer controller

This block sits between a host bus and an analog-to-digital converter. It decides what starts each conversion and how the result is handed back to the host. A small mode register is loaded by a host write strobe. Its 3-bit code, together with a board strap, picks one trigger source and the paths that announce completion. The trigger source is one of: a software trigger strobe, a periodic pacer tick, or an external trigger pin. The completion paths are an active-low ready flag for polling, an interrupt request, and a DMA request.

The converter is driven through a plain start/done handshake. A start pulse marks the converter busy. The matching done pulse ends the conversion and captures the result word. A trigger that arrives while the converter is busy is dropped. All pins are plain control and status signals. There is no streaming interface, so back-pressure does not apply. A result stays in its holding register until the next conversion completes, whether or not the host has read it.

Top module: `adc_xfer_ctrl`

## Requirements
- R1: After reset the mode code is 000, `adc_start` is 0, `ready_n` is 1, `irq` is 0 and `dma_req` is 0.
- R2: On `mode_wr`, only bits 2..0 of `mode_wdata` are stored. Bits 7..3 have no effect; for example, writing 0xF9 behaves exactly like writing 0x01.
- R3: With `ext_sel`=0 and code 001, a `sw_trig` strobe sampled at one clock edge makes `adc_start` high for exactly the following cycle. Pacer ticks are ignored. Completion sets only the ready flag (`ready_n`=0).
- R4: With `ext_sel`=0 and code 010, a `pacer_tick` starts a conversion with the same one-cycle timing as R3. Completion raises `dma_req` only, and `ready_n` stays 1. Software strobes are ignored.
- R5: With `ext_sel`=0 and code 110, a `pacer_tick` starts a conversion. Completion raises `irq` and also drives `ready_n` to 0.
- R6: With `ext_sel`=1, code 010 uses external trigger and DMA, and code 110 uses external trigger with interrupt and polling. Software and pacer triggers are ignored. A rising edge on `ext_trig` first sampled high at edge k gives `adc_start` high in the cycle after edge k+2. A level held high starts only one conversion.
- R7: Code 000, codes 011, 100, 101 and 111, and code 001 with `ext_sel`=1 start no conversion and raise no flag.
- R8: The converter is busy from the start pulse until `adc_done`. A trigger received while it is busy is dropped: it is neither queued nor counted.
- R9: An `adc_done` pulse while the converter is not busy changes no output.
- R10: `ready_n` returns to 1 on `res_rd`. `irq` holds until `irq_ack`. `dma_req` holds until `dma_ack`. If a new completion and the clear arrive in the same cycle, the completion wins.
- R11: `res_data` takes the value of `adc_data` at the edge where a completion is accepted, and holds it until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Host write strobe for the mode register |
| mode_wdata | input | 8 | Host write data; only bits 2..0 are used |
| sw_trig | input | 1 | Host write strobe to the software trigger register |
| ext_sel | input | 1 | Strap: 0 selects internal triggers, 1 selects the external pin |
| pacer_tick | input | 1 | One-cycle periodic tick from the pacer timer |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_done | input | 1 | Converter completion pulse |
| adc_data | input | DATA_W | Converter result word |
| res_data | output | DATA_W | Held result of the last completion |
| ready_n | output | 1 | Result-ready flag, active low |
| res_rd | input | 1 | Host read of the result; sets `ready_n` back to 1 |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge |

## Verification
A trigger from software or the pacer gives `adc_start` one cycle after the edge that samples it. An external edge takes three cycles, because it passes through two synchronizer stages and an edge detector. The result, ready, interrupt and DMA outputs change one cycle after the edge that accepts `adc_done` or an acknowledge. The bench runs a behavioural model that updates on the same edges and compares it with every output at each falling edge. Directed checks then sample the outputs at exactly these cycle offsets from each stimulus, and nothing is sampled at the active edge.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;

  localparam int MODE_BITS = 3;

  localparam logic [MODE_BITS-1:0] CODE_OFF   = 3'b000;
  localparam logic [MODE_BITS-1:0] CODE_SWPOLL = 3'b001;
  localparam logic [MODE_BITS-1:0] CODE_DMA   = 3'b010;
  localparam logic [MODE_BITS-1:0] CODE_IRQ   = 3'b110;

  typedef struct packed {
    logic sw;
    logic pacer;
    logic ext;
    logic poll;
    logic irq;
    logic dma;
  } path_en_t;

endpackage

// File: rtl/adc_mode_decode.sv
module adc_mode_decode
  import adc_xfer_pkg::*;
(
  input  logic                 ext_sel,
  input  logic [MODE_BITS-1:0] code,
  output path_en_t             en
);

  always_comb begin
    en = '0;
    unique case (code)
      CODE_SWPOLL: begin
        en.sw   = !ext_sel;
        en.poll = !ext_sel;
      end
      CODE_DMA: begin
        en.pacer = !ext_sel;
        en.ext   = ext_sel;
        en.dma   = 1'b1;
      end
      CODE_IRQ: begin
        en.pacer = !ext_sel;
        en.ext   = ext_sel;
        en.irq   = 1'b1;
        en.poll  = 1'b1;
      end
      default: en = '0;
    endcase
  end

endmodule

// File: rtl/adc_trig_unit.sv
module adc_trig_unit
  import adc_xfer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  path_en_t en,
  input  logic     sw_trig,
  input  logic     pacer_tick,
  input  logic     ext_pin,
  input  logic     adc_done,
  output logic     adc_start,
  output logic     busy,
  output logic     done_ev
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] ext_sh;
  logic            ext_rise;
  logic            fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sh <= '0;
    else        ext_sh <= {ext_sh[SH_W-2:0], ext_pin};
  end

  assign ext_rise = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];

  assign fire = (en.sw & sw_trig) | (en.pacer & pacer_tick) | (en.ext & ext_rise);
  assign done_ev = busy & adc_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_start <= 1'b0;
      busy      <= 1'b0;
    end else begin
      adc_start <= fire & ~busy;
      if (fire & ~busy)  busy <= 1'b1;
      else if (done_ev)  busy <= 1'b0;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R3
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> !$past(busy)); // R8
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy); // R8

endmodule

// File: rtl/adc_result_path.sv
module adc_result_path
  import adc_xfer_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  path_en_t          en,
  input  logic              done_ev,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              res_rd,
  input  logic              irq_ack,
  input  logic              dma_ack,
  output logic [DATA_W-1:0] res_data,
  output logic              ready_n,
  output logic              irq,
  output logic              dma_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data <= '0;
      ready_n  <= 1'b1;
      irq      <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      if (done_ev) res_data <= adc_data;

      if (done_ev & en.poll) ready_n <= 1'b0;
      else if (res_rd)       ready_n <= 1'b1;

      if (done_ev & en.irq)  irq <= 1'b1;
      else if (irq_ack)      irq <= 1'b0;

      if (done_ev & en.dma)  dma_req <= 1'b1;
      else if (dma_ack)      dma_req <= 1'b0;
    end
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R10
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req); // R10
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_ev |=> $stable(res_data)); // R11

endmodule

// File: rtl/adc_xfer_ctrl.sv
module adc_xfer_ctrl
  import adc_xfer_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [7:0]        mode_wdata,
  input  logic              sw_trig,
  input  logic              ext_sel,
  input  logic              pacer_tick,
  input  logic              ext_trig,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic [DATA_W-1:0] res_data,
  output logic              ready_n,
  input  logic              res_rd,
  output logic              irq,
  input  logic              irq_ack,
  output logic              dma_req,
  input  logic              dma_ack
);

  logic [MODE_BITS-1:0] mode_q;
  path_en_t             en;
  logic                 busy;
  logic                 done_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= CODE_OFF;
    else if (mode_wr) mode_q <= mode_wdata[MODE_BITS-1:0];
  end

  adc_mode_decode u_dec (
    .ext_sel (ext_sel),
    .code    (mode_q),
    .en      (en)
  );

  adc_trig_unit #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .sw_trig    (sw_trig),
    .pacer_tick (pacer_tick),
    .ext_pin    (ext_trig),
    .adc_done   (adc_done),
    .adc_start  (adc_start),
    .busy       (busy),
    .done_ev    (done_ev)
  );

  adc_result_path #(.DATA_W(DATA_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .done_ev  (done_ev),
    .adc_data (adc_data),
    .res_rd   (res_rd),
    .irq_ack  (irq_ack),
    .dma_ack  (dma_ack),
    .res_data (res_data),
    .ready_n  (ready_n),
    .irq      (irq),
    .dma_req  (dma_req)
  );

  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(en.sw | en.pacer | en.ext) |=> !adc_start); // R7
  AST_READY_NEEDS_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> $past(en.poll)); // R4
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_ev)); // R9

endmodule

// File: tb/adc_xfer_ctrl_tb.sv
module adc_xfer_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 0, sw_trig = 0, ext_sel = 0, pacer_tick = 0, ext_trig = 0;
  logic adc_done = 0, res_rd = 0, irq_ack = 0, dma_ack = 0;
  logic [7:0] mode_wdata = '0;
  logic [DW-1:0] adc_data = '0;
  logic adc_start, ready_n, irq, dma_req;
  logic [DW-1:0] res_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_xfer_ctrl #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .sw_trig(sw_trig), .ext_sel(ext_sel), .pacer_tick(pacer_tick),
    .ext_trig(ext_trig), .adc_start(adc_start), .adc_done(adc_done),
    .adc_data(adc_data), .res_data(res_data), .ready_n(ready_n),
    .res_rd(res_rd), .irq(irq), .irq_ack(irq_ack), .dma_req(dma_req),
    .dma_ack(dma_ack)
  );

  // behavioural reference model
  int m_mode;
  bit m_busy, m_start, m_rdy_n, m_irq, m_dma;
  int m_data;
  bit x1, x2, x3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_busy = 0; m_start = 0; m_rdy_n = 1; m_irq = 0; m_dma = 0;
      m_data = 0; x1 = 0; x2 = 0; x3 = 0;
    end else begin
      bit use_sw, use_pacer, use_ext, want_poll, want_irq, want_dma, edge_seen, go, fin;
      use_sw = 0; use_pacer = 0; use_ext = 0; want_poll = 0; want_irq = 0; want_dma = 0;
      if (m_mode == 1 && !ext_sel) begin use_sw = 1; want_poll = 1; end
      if (m_mode == 2) begin want_dma = 1; if (ext_sel) use_ext = 1; else use_pacer = 1; end
      if (m_mode == 6) begin want_irq = 1; want_poll = 1; if (ext_sel) use_ext = 1; else use_pacer = 1; end
      edge_seen = x2 && !x3;
      go = (use_sw && sw_trig) || (use_pacer && pacer_tick) || (use_ext && edge_seen);
      fin = m_busy && adc_done;
      if (fin) begin
        m_data = adc_data;
        if (want_poll) m_rdy_n = 0; else if (res_rd) m_rdy_n = 1;
        if (want_irq) m_irq = 1; else if (irq_ack) m_irq = 0;
        if (want_dma) m_dma = 1; else if (dma_ack) m_dma = 0;
      end else begin
        if (res_rd) m_rdy_n = 1;
        if (irq_ack) m_irq = 0;
        if (dma_ack) m_dma = 0;
      end
      m_start = go && !m_busy;
      if (go && !m_busy) m_busy = 1; else if (fin) m_busy = 0;
      x3 = x2; x2 = x1; x1 = ext_trig;
      if (mode_wr) m_mode = mode_wdata % 8;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R3/R8 adc_start vs model", adc_start, m_start);
      chk("R10 ready_n vs model", ready_n, m_rdy_n);
      chk("R5 irq vs model", irq, m_irq);
      chk("R4 dma_req vs model", dma_req, m_dma);
      chk("R11 res_data vs model", res_data, m_data);
    end
  endtask

  task automatic set_mode(input logic [7:0] v);
    mode_wdata = v; mode_wr = 1; cyc(1); mode_wr = 0;
  endtask

  task automatic finish_conv(input logic [DW-1:0] d);
    adc_data = d; adc_done = 1; cyc(1); adc_done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(1);
    chk("R1 adc_start reset", adc_start, 0);
    chk("R1 ready_n reset", ready_n, 1);
    chk("R1 irq reset", irq, 0);
    chk("R1 dma_req reset", dma_req, 0);
    sw_trig = 1; cyc(1); sw_trig = 0;
    chk("R1 code 000 after reset blocks sw", adc_start, 0);

    // R2 / R3: 0xF9 acts as 001
    set_mode(8'hF9);
    pacer_tick = 1; cyc(1); pacer_tick = 0;
    chk("R3 pacer ignored in 001", adc_start, 0);
    sw_trig = 1; cyc(1); sw_trig = 0;
    chk("R2 upper bits ignored, sw starts", adc_start, 1);
    cyc(1);
    chk("R3 start lasts one cycle", adc_start, 0);
    finish_conv(12'hABC);
    chk("R3 ready_n low", ready_n, 0);
    chk("R3 no irq", irq, 0);
    chk("R3 no dma", dma_req, 0);
    chk("R11 data captured", res_data, 12'hABC);
    res_rd = 1; cyc(1); res_rd = 0;
    chk("R10 ready_n cleared by read", ready_n, 1);

    // R4 and R8
    set_mode(8'h02);
    sw_trig = 1; cyc(1); sw_trig = 0;
    chk("R4 sw ignored in 010", adc_start, 0);
    pacer_tick = 1; cyc(1); pacer_tick = 0;
    chk("R4 pacer starts", adc_start, 1);
    pacer_tick = 1; cyc(1); pacer_tick = 0;
    chk("R8 trigger while busy dropped", adc_start, 0);
    cyc(2);
    finish_conv(12'h123);
    chk("R4 dma raised", dma_req, 1);
    chk("R4 ready_n stays high", ready_n, 1);
    cyc(3);
    chk("R10 dma held", dma_req, 1);
    chk("R8 no queued start", adc_start, 0);
    dma_ack = 1; cyc(1); dma_ack = 0;
    chk("R10 dma cleared by ack", dma_req, 0);

    // R9
    finish_conv(12'h777);
    chk("R9 stray done no dma", dma_req, 0);
    chk("R9 stray done keeps data", res_data, 12'h123);

    // R10 set wins
    pacer_tick = 1; cyc(1); pacer_tick = 0;
    finish_conv(12'h001);
    pacer_tick = 1; cyc(1); pacer_tick = 0;
    adc_data = 12'h002; adc_done = 1; dma_ack = 1; cyc(1); adc_done = 0; dma_ack = 0;
    chk("R10 completion beats ack", dma_req, 1);
    dma_ack = 1; cyc(1); dma_ack = 0;

    // R5
    set_mode(8'h06);
    pacer_tick = 1; cyc(1); pacer_tick = 0;
    chk("R5 pacer starts", adc_start, 1);
    finish_conv(12'h5A5);
    chk("R5 irq raised", irq, 1);
    chk("R5 ready_n low", ready_n, 0);
    cyc(2);
    chk("R10 irq held", irq, 1);
    irq_ack = 1; res_rd = 1; cyc(1); irq_ack = 0; res_rd = 0;
    chk("R10 irq cleared", irq, 0);

    // R7
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 2 || c == 6) continue;
      set_mode(8'(c));
      sw_trig = 1; pacer_tick = 1; cyc(1); sw_trig = 0; pacer_tick = 0;
      chk("R7 disabled code no start", adc_start, 0);
    end

    // R6 external
    ext_sel = 1;
    set_mode(8'h02);
    sw_trig = 1; pacer_tick = 1; cyc(1); sw_trig = 0; pacer_tick = 0;
    chk("R6 internal ignored when external", adc_start, 0);
    ext_trig = 1; cyc(2);
    chk("R6 no start before sync", adc_start, 0);
    cyc(1);
    chk("R6 start three cycles after pin", adc_start, 1);
    cyc(4);
    chk("R6 held level one start only", adc_start, 0);
    finish_conv(12'hE01);
    chk("R6 dma in ext 010", dma_req, 1);
    dma_ack = 1; ext_trig = 0; cyc(1); dma_ack = 0;
    set_mode(8'h06);
    cyc(2);
    ext_trig = 1; cyc(3);
    chk("R6 ext start in 110", adc_start, 1);
    finish_conv(12'hE02);
    chk("R6 irq in ext 110", irq, 1);
    chk("R6 ready_n in ext 110", ready_n, 0);
    irq_ack = 1; res_rd = 1; ext_trig = 0; cyc(1); irq_ack = 0; res_rd = 0;
    set_mode(8'h01);
    cyc(2);
    ext_trig = 1; cyc(4);
    chk("R7 ext with 001 disabled", adc_start, 0);
    ext_trig = 0;
    cyc(2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule